// File: doc/BRIEF.md
# Masked Packed-Integer Vector Adder

This block adds two 128-bit operand vectors as a set of independent packed integer lanes, with every lane working in lockstep on the same operation. Each operation picks its own lane width: sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Per operation it also picks between wrapping and signed saturating arithmetic.

A per-byte predicate mask decides which lanes are written. This lets conditional work be expressed without branching. A lane whose enable bit is clear passes the matching bits of the old destination value through to the result.

The sum is registered. The result and its valid flag appear one clock after the input strobe. The result holds its value until the next strobe arrives.

Top module: `simd_masked_add`

## Requirements
- R1: The width select encodes the lane width as 2'b00 for 8-bit lanes, 2'b01 for 16-bit lanes and 2'b10 for 32-bit lanes. Lane k occupies bits [k*W +: W] of each operand, and each enabled lane's result is the sum of its two operand lanes.
- R2: No carry passes from one lane into the next. A lane whose sum overflows leaves its neighbours unchanged.
- R3: With saturation on, a lane overflows when both operands have the same sign and the raw sum has the other sign. An overflowing lane is clamped to the largest positive value (0x7F, 0x7FFF or 0x7FFFFFFF) or to the most negative value (0x80, 0x8000 or 0x80000000), whichever matches the operands' sign.
- R4: With saturation off, every lane wraps modulo 2^W.
- R5: The mask has one bit per byte: bit j belongs to byte j of the vector. A lane of W bits starting at byte s is enabled by mask bit s alone, and the lane's other mask bits are ignored.
- R6: A disabled lane takes its result bits from the old destination input.
- R7: Width select 2'b11 is reserved. With it, the whole result equals the old destination input.
- R8: out_valid is high in exactly the cycle after a cycle with in_valid high. The matching result is present in that same cycle.
- R9: Driving rst_n low clears out_valid and the result to zero at once. Operation resumes two clock edges after rst_n is released.
- R10: While in_valid is low, the result register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation strobe |
| esz | input | 2 | Lane width select (00: 8-bit, 01: 16-bit, 10: 32-bit, 11: reserved) |
| sat_en | input | 1 | Signed saturation enable |
| lane_mask | input | 16 | Per-byte predicate mask; each lane uses the bit of its lowest byte |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| dst_old | input | 128 | Old destination value, used for disabled lanes |
| out_valid | output | 1 | High one cycle after in_valid |
| result | output | 128 | Registered result vector |

## Verification
Every arithmetic and merge result is due exactly one rising edge after the strobe. The bench therefore drives inputs on a falling edge and compares out_valid and the whole result on the next falling edge, against a lane-by-lane integer model built from the requirements. Idle cycles are compared in the same way, to confirm that the previous result is held and that out_valid stays low. The effect of reset is asynchronous, so it is checked one nanosecond after rst_n falls, without waiting for a clock edge.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic [1:0] {
    ESZ_8   = 2'b00,
    ESZ_16  = 2'b01,
    ESZ_32  = 2'b10,
    ESZ_RSV = 2'b11
  } esz_e;

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_add_pkg::*;
#(
  parameter int NSEG  = 16,
  parameter int IDX_W = $clog2(NSEG)
) (
  input  esz_e                        esz,
  output logic [NSEG-1:0]             seg_first,
  output logic [NSEG-1:0][IDX_W-1:0]  seg_base,
  output logic [NSEG-1:0][IDX_W-1:0]  seg_top
);

  logic [IDX_W-1:0] span;

  // number of extra segments in a lane, as a low-bit mask
  always_comb begin
    case (esz)
      ESZ_16:  span = IDX_W'(1);
      ESZ_32:  span = IDX_W'(3);
      default: span = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      seg_base[i]  = IDX_W'(i) & ~span;
      seg_top[i]   = IDX_W'(i) | span;
      seg_first[i] = ((IDX_W'(i) & span) == '0);
    end
  end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int NSEG  = 16,
  parameter int SEG_W = 8,
  localparam int VW   = NSEG * SEG_W
) (
  input  logic [VW-1:0]   op_a,
  input  logic [VW-1:0]   op_b,
  input  logic [NSEG-1:0] seg_first,
  output logic [VW-1:0]   raw_sum
);

  logic [NSEG-1:0] cin;
  logic [NSEG-2:0] cout;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    // a lane's first segment never takes the carry of the segment below it
    if (g == 0) begin : g_lo
      assign cin[g] = 1'b0;
    end else begin : g_hi
      assign cin[g] = ~seg_first[g] & cout[g-1];
    end

    if (g == NSEG - 1) begin : g_last
      assign raw_sum[g*SEG_W +: SEG_W] =
        op_a[g*SEG_W +: SEG_W] + op_b[g*SEG_W +: SEG_W] + {{(SEG_W-1){1'b0}}, cin[g]};
    end else begin : g_mid
      assign {cout[g], raw_sum[g*SEG_W +: SEG_W]} =
        {1'b0, op_a[g*SEG_W +: SEG_W]} + {1'b0, op_b[g*SEG_W +: SEG_W]}
        + {{SEG_W{1'b0}}, cin[g]};
    end
  end

endmodule

// File: rtl/simd_sat_merge.sv
module simd_sat_merge
  import simd_add_pkg::*;
#(
  parameter int NSEG  = 16,
  parameter int SEG_W = 8,
  parameter int IDX_W = $clog2(NSEG),
  localparam int VW   = NSEG * SEG_W
) (
  input  esz_e                        esz,
  input  logic                        sat_en,
  input  logic [NSEG-1:0]             lane_mask,
  input  logic [VW-1:0]               op_a,
  input  logic [VW-1:0]               op_b,
  input  logic [VW-1:0]               raw_sum,
  input  logic [VW-1:0]               dst_old,
  input  logic [NSEG-1:0][IDX_W-1:0]  seg_base,
  input  logic [NSEG-1:0][IDX_W-1:0]  seg_top,
  output logic [VW-1:0]               merged
);

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      int          hi;
      logic        sa, sb, ss, ovf, on;
      logic [SEG_W-1:0] seg;
      hi  = int'(seg_top[i]) * SEG_W + SEG_W - 1;
      sa  = op_a[hi];
      sb  = op_b[hi];
      ss  = raw_sum[hi];
      ovf = sat_en && (sa == sb) && (ss != sa);
      if (ovf) begin
        if (IDX_W'(i) == seg_top[i]) seg = sa ? {1'b1, {(SEG_W-1){1'b0}}}
                                             : {1'b0, {(SEG_W-1){1'b1}}};
        else                         seg = sa ? '0 : '1;
      end else begin
        seg = raw_sum[i*SEG_W +: SEG_W];
      end
      on = lane_mask[seg_base[i]] && (esz != ESZ_RSV);
      merged[i*SEG_W +: SEG_W] = on ? seg : dst_old[i*SEG_W +: SEG_W];
    end
  end

endmodule

// File: rtl/simd_masked_add.sv
module simd_masked_add
  import simd_add_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int SEG_W  = 8,
  localparam int NSEG  = VEC_W / SEG_W,
  localparam int IDX_W = $clog2(NSEG),
  localparam int L16   = 2 * SEG_W,
  localparam int L32   = 4 * SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       esz,
  input  logic             sat_en,
  input  logic [NSEG-1:0]  lane_mask,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [VEC_W-1:0] dst_old,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);

  esz_e                       esz_t;
  logic [1:0]                 rst_sync;
  logic                       rst_ok_n;
  logic [NSEG-1:0]            seg_first;
  logic [NSEG-1:0][IDX_W-1:0] seg_base;
  logic [NSEG-1:0][IDX_W-1:0] seg_top;
  logic [VEC_W-1:0]           raw_sum;
  logic [VEC_W-1:0]           merged;
  logic [VEC_W-1:0]           res_d, res_q;
  logic                       vld_q;

  assign esz_t = esz_e'(esz);

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  simd_lane_map #(.NSEG(NSEG), .IDX_W(IDX_W)) u_map (
    .esz       (esz_t),
    .seg_first (seg_first),
    .seg_base  (seg_base),
    .seg_top   (seg_top)
  );

  simd_seg_adder #(.NSEG(NSEG), .SEG_W(SEG_W)) u_add (
    .op_a      (op_a),
    .op_b      (op_b),
    .seg_first (seg_first),
    .raw_sum   (raw_sum)
  );

  simd_sat_merge #(.NSEG(NSEG), .SEG_W(SEG_W), .IDX_W(IDX_W)) u_sat (
    .esz       (esz_t),
    .sat_en    (sat_en),
    .lane_mask (lane_mask),
    .op_a      (op_a),
    .op_b      (op_b),
    .raw_sum   (raw_sum),
    .dst_old   (dst_old),
    .seg_base  (seg_base),
    .seg_top   (seg_top),
    .merged    (merged)
  );

  // next state: load on strobe, hold otherwise
  always_comb begin
    res_d = res_q;
    if (in_valid) res_d = merged;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  // R8: strobe produces valid one cycle later
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_valid |=> out_valid);

  // R10: no strobe, no valid and no change of the result
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R7: reserved width passes the old destination through
  p_rsv_pass_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && esz_t == ESZ_RSV) |=> (result == $past(dst_old)));

  // R6: lowest lane disabled keeps the old byte
  p_mask_off_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && esz_t != ESZ_RSV && !lane_mask[0])
    |=> (result[SEG_W-1:0] == $past(dst_old[SEG_W-1:0])));

  // R2: second 32-bit lane is its own wrapping sum
  p_lane_iso_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && esz_t == ESZ_32 && !sat_en && lane_mask[4])
    |=> (result[2*L32-1:L32] == $past(op_a[2*L32-1:L32] + op_b[2*L32-1:L32])));

  // R3: two non-negative 16-bit operands never give a negative lane
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && sat_en && esz_t == ESZ_16 && lane_mask[0]
     && !op_a[L16-1] && !op_b[L16-1]) |=> !result[L16-1]);

endmodule

// File: tb/tb_simd_masked_add.sv
module tb_simd_masked_add;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   esz;
  logic         sat_en;
  logic [15:0]  lane_mask;
  logic [127:0] op_a, op_b, dst_old;
  logic         out_valid;
  logic [127:0] result;

  int n_chk;
  int n_fail;
  logic         exp_vld;
  logic [127:0] exp_res;

  simd_masked_add dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esz(esz), .sat_en(sat_en),
    .lane_mask(lane_mask), .op_a(op_a), .op_b(op_b), .dst_old(dst_old),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] model(logic [1:0] e, logic s, logic [15:0] m,
                                         logic [127:0] a, logic [127:0] b,
                                         logic [127:0] old);
    logic [127:0] r;
    int w, n;
    longint lm, ua, ub, sa, sb, sum, hi, lo;
    if (e == 2'b11) return old;
    r  = old;
    w  = 8 << e;
    n  = 128 / w;
    lm = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    for (int l = 0; l < n; l++) begin
      ua = longint'(a >> (l * w)) & lm;
      ub = longint'(b >> (l * w)) & lm;
      sa = ((ua >> (w - 1)) & 1) != 0 ? ua - (longint'(1) << w) : ua;
      sb = ((ub >> (w - 1)) & 1) != 0 ? ub - (longint'(1) << w) : ub;
      sum = sa + sb;
      if (s) begin
        if (sum > hi) sum = hi;
        if (sum < lo) sum = lo;
      end
      if (m[l * w / 8]) begin
        r = r & ~(128'(lm) << (l * w));
        r = r | (128'(sum & lm) << (l * w));
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] want);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic cyc(string req, logic v, logic [1:0] e, logic s, logic [15:0] m,
                     logic [127:0] a, logic [127:0] b, logic [127:0] old);
    logic [127:0] nres;
    in_valid = v; esz = e; sat_en = s; lane_mask = m;
    op_a = a; op_b = b; dst_old = old;
    nres = v ? model(e, s, m, a, b, old) : exp_res;
    @(negedge clk);
    exp_vld = v;
    exp_res = nres;
    check(req, {127'b0, out_valid}, {127'b0, exp_vld});
    check(req, result, exp_res);
  endtask

  task automatic idle(string req, int k);
    for (int i = 0; i < k; i++) cyc(req, 1'b0, 2'($urandom), 1'b1, 16'hFFFF,
                                    rnd128(), rnd128(), rnd128());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; esz = 2'b00; sat_en = 1'b0;
    lane_mask = '0; op_a = '0; op_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    // R9: held in reset
    check("R9", {127'b0, out_valid}, 128'd0);
    check("R9", result, 128'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_vld = 1'b0; exp_res = '0;

    // R1 and R4: random wrapping sums for each width
    for (int e = 0; e < 3; e++)
      for (int k = 0; k < 20; k++)
        cyc("R1", 1'b1, 2'(e), 1'b0, 16'hFFFF, rnd128(), rnd128(), rnd128());

    // R2: every lane overflows, neighbours must stay clean
    cyc("R2", 1'b1, 2'b00, 1'b0, 16'hFFFF, {16{8'hFF}}, {16{8'h01}}, rnd128());
    cyc("R2", 1'b1, 2'b01, 1'b0, 16'hFFFF, {8{16'hFFFF}}, {8{16'h0001}}, rnd128());
    cyc("R2", 1'b1, 2'b10, 1'b0, 16'hFFFF, {4{32'hFFFFFFFF}}, {4{32'h00000001}}, rnd128());

    // R4: signed overflow wraps when saturation is off
    cyc("R4", 1'b1, 2'b01, 1'b0, 16'hFFFF, {8{16'h7000}}, {8{16'h7000}}, '0);
    cyc("R4", 1'b1, 2'b00, 1'b0, 16'hFFFF, {16{8'h80}}, {16{8'hFF}}, '0);

    // R3: clamping for each width, both directions, plus no-overflow lanes
    cyc("R3", 1'b1, 2'b01, 1'b1, 16'hFFFF,
        {4{16'h7000, 16'h8000}}, {4{16'h7000, 16'hFFFF}}, '0);
    cyc("R3", 1'b1, 2'b00, 1'b1, 16'hFFFF,
        {4{8'h7F, 8'h80, 8'h01, 8'hF0}}, {4{8'h01, 8'h80, 8'h02, 8'hF0}}, '0);
    cyc("R3", 1'b1, 2'b10, 1'b1, 16'hFFFF,
        {32'h7FFFFFFF, 32'h80000000, 32'h12345678, 32'hFFFFFFFF},
        {32'h00000001, 32'hFFFFFFFF, 32'h11111111, 32'hFFFFFFFF}, '0);
    for (int e = 0; e < 3; e++)
      for (int k = 0; k < 20; k++)
        cyc("R3", 1'b1, 2'(e), 1'b1, 16'hFFFF, rnd128(), rnd128(), rnd128());

    // R5: only a lane's lowest-byte bit enables it
    cyc("R5", 1'b1, 2'b10, 1'b0, 16'hEEEE, rnd128(), rnd128(), rnd128());
    cyc("R5", 1'b1, 2'b10, 1'b0, 16'h1111, rnd128(), rnd128(), rnd128());
    cyc("R5", 1'b1, 2'b01, 1'b1, 16'hAAAA, rnd128(), rnd128(), rnd128());
    cyc("R5", 1'b1, 2'b01, 1'b1, 16'h5555, rnd128(), rnd128(), rnd128());

    // R6: random masks merge with the old destination
    for (int k = 0; k < 40; k++)
      cyc("R6", 1'b1, 2'($urandom_range(0, 2)), 1'($urandom), 16'($urandom),
          rnd128(), rnd128(), rnd128());
    cyc("R6", 1'b1, 2'b00, 1'b0, 16'h0000, rnd128(), rnd128(), rnd128());

    // R7: reserved width
    cyc("R7", 1'b1, 2'b11, 1'b0, 16'hFFFF, rnd128(), rnd128(), rnd128());
    cyc("R7", 1'b1, 2'b11, 1'b1, 16'hFFFF, rnd128(), rnd128(), rnd128());

    // R8 and R10: gaps between strobes, results held
    cyc("R8", 1'b1, 2'b00, 1'b0, 16'hFFFF, rnd128(), rnd128(), rnd128());
    idle("R10", 4);
    cyc("R8", 1'b1, 2'b10, 1'b1, 16'hFFFF, rnd128(), rnd128(), rnd128());
    idle("R10", 1);
    cyc("R8", 1'b1, 2'b01, 1'b0, 16'h0F0F, rnd128(), rnd128(), rnd128());
    cyc("R8", 1'b1, 2'b01, 1'b1, 16'hF0F0, rnd128(), rnd128(), rnd128());
    idle("R10", 2);

    // R9: reset in mid-run clears at once
    cyc("R9", 1'b1, 2'b00, 1'b0, 16'hFFFF, rnd128(), rnd128(), rnd128());
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R9", {127'b0, out_valid}, 128'd0);
    check("R9", result, 128'd0);
    exp_vld = 1'b0; exp_res = '0;
    @(negedge clk);
    rst_n = 1'b1;
    idle("R9", 3);
    cyc("R9", 1'b1, 2'b01, 1'b1, 16'hFFFF, rnd128(), rnd128(), rnd128());
    idle("R10", 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule